// File: doc/BRIEF.md
# Pulse-Per-Second Capture and Monitor

This block watches an external one-pulse-per-second signal from inside a streaming clock domain. The pin is sampled on a rising or falling clock edge, as software chooses, and then passes through a resynchronising chain. Each 0-to-1 transition that comes out of the chain produces a one-cycle internal strobe for downstream logic.

The block counts clock cycles between successive strobes and keeps the latest measured period. It also keeps a toggle level that inverts on every strobe, and a sticky flag. The flag stays set only while every period measured since the last status read has matched a programmable expected count. A free-running counter gives the number of cycles elapsed since the most recent strobe.

Software reaches all of this through four 32-bit words on a word-addressed register port. Read data is registered.

Top module: `pps_monitor`

## Requirements
- R1: After reset, ppsStrobe is 0, word 0 reads 0x4000_0000 (flag set, toggle 0, period 0), word 1 reads the reset expected count (default 200,000,000) with edge select 0, and word 2 reads the cycles counted since reset.
- R2: With edge select 0, a pin value present at rising clock edge E that is 1 after a 0 at edge E-1 makes ppsStrobe high for exactly one cycle, in the cycle that follows edge E+3.
- R3: With edge select 1, the pin is captured on the falling clock edge. A pin that rises shortly after rising edge E-1 and stays high through the next falling edge makes ppsStrobe high in the cycle after edge E+2, which is one cycle earlier than with edge select 0.
- R4: Word 0 bits [29:0] hold the number of clock cycles from the start of the previous strobe to the start of the latest strobe. The first strobe after reset does not update this field.
- R5: Word 0 bit 31 is a level that inverts on every strobe, including the first.
- R6: Word 0 bit 30 clears when a strobe ends a period whose measured length differs from the expected count. The first strobe after reset never clears it.
- R7: A read of word 0 sets bit 30 back to 1 for the following window. When a mismatching strobe is detected in the same cycle as that read, the bit ends up 0. The read itself returns the flag value from before that cycle.
- R8: Word 1 is read/write. Bits [29:0] hold the expected count and bit 31 holds the edge select. Bit 30 reads 0 whatever value is written to it.
- R9: Word 2 returns the number of cycles since the start of the latest strobe, as counted in the cycle in which rd is asserted. A read issued in a strobe cycle returns 0.
- R10: Read data appears on mmRdData in the cycle after mmRd and holds until the next read. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streaming clock |
| rst | input | 1 | Synchronous reset, active high |
| ppsIn | input | 1 | External pulse-per-second pin, asynchronous |
| mmAddr | input | 2 | Word address |
| mmWr | input | 1 | Write strobe |
| mmWrData | input | 32 | Write data |
| mmRd | input | 1 | Read strobe |
| mmRdData | output | 32 | Registered read data |
| ppsStrobe | output | 1 | One-cycle internal pulse per detected PPS |

## Verification
Two functions can land in the same cycle. The first is a status read, which re-arms the sticky flag. The second is a strobe that ends a mismatching period, which clears the flag. The bench provokes this by sweeping the read of word 0 across several cycles around the detection of a deliberately short period, so that one sweep point falls exactly on the detection cycle. A behavioural model, updated on every clock, judges each point: the flag must read back 0 at the next status read, and the coinciding read must return the value the flag had before that cycle. The same sweep also makes an offset read meet a strobe cycle.

// File: rtl/pps_mon_pkg.sv
package pps_mon_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    WORD_STATUS = 2'd0,
    WORD_CONFIG = 2'd1,
    WORD_OFFSET = 2'd2,
    WORD_SPARE  = 2'd3
  } word_sel_t;

  typedef struct packed {
    logic      pulse;     // detected PPS this cycle
    logic      rdEn;      // read access this cycle
    logic      wrCfg;     // write to config word
    logic      clrStable; // status read re-arms the flag
    word_sel_t sel;       // addressed word
  } ctrl_strobes_t;

endpackage

// File: rtl/pps_mon_ctrl.sv
module pps_mon_ctrl
  import pps_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ppsIn,
  input  logic              edgeSel,
  input  logic [ADDR_W-1:0] mmAddr,
  input  logic              mmWr,
  input  logic              mmRd,
  output ctrl_strobes_t     ctrl,
  output logic              ppsStrobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic riseQ;
  logic fallQ;
  logic sampled;
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic detect;
  logic strobeQ;

  always_ff @(posedge clk) begin
    if (rst) riseQ <= 1'b0;
    else     riseQ <= ppsIn;
  end

  always_ff @(negedge clk) begin
    if (rst) fallQ <= 1'b0;
    else     fallQ <= ppsIn;
  end

  assign sampled = edgeSel ? fallQ : riseQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= sampled;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], sampled};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ   <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      prevQ   <= syncQ[LAST];
      strobeQ <= detect;
    end
  end

  assign detect = syncQ[LAST] & ~prevQ;

  always_comb begin
    ctrl.pulse     = detect;
    ctrl.rdEn      = mmRd;
    ctrl.wrCfg     = mmWr && (mmAddr == WORD_CONFIG);
    ctrl.clrStable = mmRd && (mmAddr == WORD_STATUS);
    ctrl.sel       = word_sel_t'(mmAddr);
  end

  assign ppsStrobe = strobeQ;

  // R2: the internal strobe never lasts more than one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    ppsStrobe |=> !ppsStrobe);

  // R2: a strobe follows a detected transition of the synchronised pin
  a_r2_strobe_after_detect: assert property (@(posedge clk) disable iff (rst)
    $rose(ppsStrobe) |-> $past(syncQ[LAST]));

endmodule

// File: rtl/pps_mon_dp.sv
module pps_mon_dp
  import pps_mon_pkg::*;
#(
  parameter int CNT_W     = 30,
  parameter int EXP_RESET = 200_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobes_t     ctrl,
  input  logic [DATA_W-1:0] wrData,
  output logic              edgeSel,
  output logic [DATA_W-1:0] rdData
);

  localparam int FIELD_W = DATA_W - 2;
  localparam int PAD_W   = FIELD_W - CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  runCnt;
  logic [CNT_W-1:0]  captCnt;
  logic [CNT_W-1:0]  expCnt;
  logic [CNT_W-1:0]  periodNow;
  logic              stableQ;
  logic              toggleQ;
  logic              seenQ;
  logic              edgeQ;
  logic [DATA_W-1:0] rdMux;
  logic              unusedWr;

  assign unusedWr  = ^wrData[DATA_W-2:CNT_W];
  assign periodNow = (runCnt == CNT_MAX) ? CNT_MAX : runCnt + 1'b1;

  function automatic logic [FIELD_W-1:0] widen(input logic [CNT_W-1:0] v);
    logic [FIELD_W-1:0] r;
    r = '0;
    r[CNT_W-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (ctrl.pulse) begin
      runCnt <= '0;
    end else if (runCnt != CNT_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      captCnt <= '0;
      toggleQ <= 1'b0;
      seenQ   <= 1'b0;
    end else if (ctrl.pulse) begin
      toggleQ <= ~toggleQ;
      seenQ   <= 1'b1;
      if (seenQ) captCnt <= periodNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stableQ <= 1'b1;
    end else if (ctrl.pulse && seenQ && (periodNow != expCnt)) begin
      stableQ <= 1'b0;
    end else if (ctrl.clrStable) begin
      stableQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      expCnt <= CNT_W'(EXP_RESET);
      edgeQ  <= 1'b0;
    end else if (ctrl.wrCfg) begin
      expCnt <= wrData[CNT_W-1:0];
      edgeQ  <= wrData[DATA_W-1];
    end
  end

  always_comb begin
    unique case (ctrl.sel)
      WORD_STATUS: rdMux = {toggleQ, stableQ, widen(captCnt)};
      WORD_CONFIG: rdMux = {edgeQ, 1'b0, widen(expCnt)};
      WORD_OFFSET: rdMux = {2'b00, widen(runCnt)};
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (ctrl.rdEn) rdData <= rdMux;
  end

  assign edgeSel = edgeQ;

  // R5: the toggle level inverts on a strobe and only then
  a_r5_toggle_flip: assert property (@(posedge clk) disable iff (rst)
    ctrl.pulse |=> (toggleQ != $past(toggleQ)));
  a_r5_toggle_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pulse |=> $stable(toggleQ));

  // R9: the offset counter restarts from zero in the strobe cycle
  a_r9_offset_restart: assert property (@(posedge clk) disable iff (rst)
    ctrl.pulse |=> (runCnt == '0));

  // R6: the flag can only drop at a detected pulse
  a_r6_drop_on_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(stableQ) |-> $past(ctrl.pulse));

  // R7: a status read with no pulse re-arms the flag
  a_r7_rearm: assert property (@(posedge clk) disable iff (rst)
    (ctrl.clrStable && !ctrl.pulse) |=> stableQ);

  // R10: the spare word reads zero
  a_r10_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl.rdEn && ctrl.sel == WORD_SPARE) |=> (rdData == '0));

  // R4: the first pulse after reset leaves the period field untouched
  a_r4_first_period: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pulse && !seenQ) |=> $stable(captCnt));

endmodule

// File: rtl/pps_monitor.sv
module pps_monitor
  import pps_mon_pkg::*;
#(
  parameter int CNT_W       = 30,
  parameter int EXP_RESET   = 200_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ppsIn,
  input  logic [1:0]  mmAddr,
  input  logic        mmWr,
  input  logic [31:0] mmWrData,
  input  logic        mmRd,
  output logic [31:0] mmRdData,
  output logic        ppsStrobe
);

  ctrl_strobes_t ctrl;
  logic          edgeSel;

  pps_mon_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ppsIn    (ppsIn),
    .edgeSel  (edgeSel),
    .mmAddr   (mmAddr),
    .mmWr     (mmWr),
    .mmRd     (mmRd),
    .ctrl     (ctrl),
    .ppsStrobe(ppsStrobe)
  );

  pps_mon_dp #(
    .CNT_W    (CNT_W),
    .EXP_RESET(EXP_RESET)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .wrData (mmWrData),
    .edgeSel(edgeSel),
    .rdData (mmRdData)
  );

endmodule

// File: tb/tb_pps_monitor.sv
`timescale 1ns/1ps
module tb_pps_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ppsIn = 1'b0;
  logic [1:0]  mmAddr = '0;
  logic        mmWr = 1'b0;
  logic [31:0] mmWrData = '0;
  logic        mmRd = 1'b0;
  logic [31:0] mmRdData;
  logic        ppsStrobe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pps_monitor dut (
    .clk(clk), .rst(rst), .ppsIn(ppsIn), .mmAddr(mmAddr), .mmWr(mmWr),
    .mmWrData(mmWrData), .mmRd(mmRd), .mmRdData(mmRdData), .ppsStrobe(ppsStrobe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int SAT = (1 << 30) - 1;
  bit   pinHist[0:4];
  int   mRun, mCapt, mExp;
  bit   mStable, mToggle, mSeen, mEdge;
  bit   expStrobe;
  bit   rdPending;
  logic [31:0] expRd;
  string rdTag;

  always @(posedge clk) begin
    bit det;
    bit per;
    int period;
    if (rst) begin
      for (int i = 0; i < 5; i++) pinHist[i] = 1'b0;
      mRun = 0; mCapt = 0; mExp = 200_000_000;
      mStable = 1'b1; mToggle = 1'b0; mSeen = 1'b0; mEdge = 1'b0;
      expStrobe = 1'b0; rdPending = 1'b0;
    end else begin
      for (int i = 4; i > 0; i--) pinHist[i] = pinHist[i-1];
      pinHist[0] = ppsIn;
      det = mEdge ? (pinHist[2] & ~pinHist[3]) : (pinHist[3] & ~pinHist[4]);
      expStrobe = det;
      rdPending = mmRd;
      if (mmRd) begin
        case (mmAddr)
          2'd0: begin expRd = {mToggle, mStable, 30'(mCapt)}; rdTag = "R4 R5 R6 R7 status"; end
          2'd1: begin expRd = {mEdge, 1'b0, 30'(mExp)};       rdTag = "R8 config"; end
          2'd2: begin expRd = {2'b00, 30'(mRun)};             rdTag = "R9 offset"; end
          default: begin expRd = 32'h0;                       rdTag = "R10 spare"; end
        endcase
      end
      period = (mRun == SAT) ? SAT : mRun + 1;
      per = det && mSeen && (period != mExp);
      if (per) mStable = 1'b0;
      else if (mmRd && mmAddr == 2'd0) mStable = 1'b1;
      if (det) begin
        mToggle = ~mToggle;
        if (mSeen) mCapt = period;
        mSeen = 1'b1;
        mRun = 0;
      end else if (mRun != SAT) begin
        mRun = mRun + 1;
      end
      if (mmWr && mmAddr == 2'd1) begin
        mExp  = int'(mmWrData[29:0]);
        mEdge = mmWrData[31];
      end
    end
    #3;
    if (!rst) begin
      chk(ppsStrobe === expStrobe, mEdge ? "R3 strobe falling" : "R2 strobe rising",
          {31'b0, ppsStrobe}, {31'b0, expStrobe});
      if (rdPending) chk(mmRdData === expRd, rdTag, mmRdData, expRd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic mmRead(input logic [1:0] a, output logic [31:0] d);
    mmAddr = a; mmRd = 1'b1;
    @(posedge clk); #1;
    mmRd = 1'b0;
    d = mmRdData;
  endtask

  task automatic mmWrite(input logic [1:0] a, input logic [31:0] d);
    mmAddr = a; mmWr = 1'b1; mmWrData = d;
    @(posedge clk); #1;
    mmWr = 1'b0;
  endtask

  task automatic pulseTrain(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      ppsIn = 1'b1; tick(3);
      ppsIn = 1'b0; tick(period - 3);
    end
  endtask

  initial begin
    logic [31:0] d;
    rst = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    tick(2);
    // R1 reset state
    chk(ppsStrobe === 1'b0, "R1 strobe idle", {31'b0, ppsStrobe}, 32'h0);
    mmRead(2'd0, d); chk(d === 32'h4000_0000, "R1 status", d, 32'h4000_0000);
    mmRead(2'd1, d); chk(d === 32'd200_000_000, "R1 config", d, 32'd200_000_000);
    mmRead(2'd3, d); chk(d === 32'h0, "R10 spare", d, 32'h0);
    // R8 bit 30 is not stored
    mmWrite(2'd1, 32'h4000_0028);
    mmRead(2'd1, d); chk(d === 32'h0000_0028, "R8 bit30 masked", d, 32'h0000_0028);

    // matching periods, rising edge
    fork
      pulseTrain(4, 40);
      begin
        tick(20); mmRead(2'd2, d);
        tick(30); mmRead(2'd0, d);
        tick(50); mmRead(2'd0, d);
        tick(30); mmRead(2'd2, d);
      end
    join
    tick(10);
    mmRead(2'd0, d);
    chk(d[30] === 1'b1 && d[29:0] === 30'd40, "R4 R6 matching period", d, {d[31], 31'h4000_0028});

    // mismatching period
    pulseTrain(2, 37);
    tick(5);
    mmRead(2'd0, d); chk(d[30] === 1'b0, "R6 mismatch clears flag", d, {d[31], 1'b0, d[29:0]});
    mmRead(2'd0, d); chk(d[30] === 1'b1, "R7 read re-arms flag", d, {d[31], 1'b1, d[29:0]});

    // same-cycle sweep: status/offset reads around a mismatching detection
    for (int off = 0; off < 8; off++) begin
      fork
        begin ppsIn = 1'b1; tick(3); ppsIn = 1'b0; tick(37);
              ppsIn = 1'b1; tick(3); ppsIn = 1'b0; tick(32);
              ppsIn = 1'b1; tick(3); ppsIn = 1'b0; tick(40); end
        begin tick(72 + off); mmRead((off % 2 == 0) ? 2'd0 : 2'd2, d);
              tick(20); mmRead(2'd0, d); end
      join
      mmRead(2'd0, d);
    end

    // falling-edge sampling
    tick(10);
    mmWrite(2'd1, 32'h8000_0028);
    tick(10);
    fork
      pulseTrain(4, 40);
      begin tick(60); mmRead(2'd2, d); tick(60); mmRead(2'd0, d); end
    join
    tick(10);
    mmRead(2'd1, d); chk(d === 32'h8000_0028, "R8 edge bit", d, 32'h8000_0028);
    mmRead(2'd0, d); chk(d[29:0] === 30'd40, "R3 R4 falling period", d, {d[31:30], 30'd40});

    // back to rising edge, offset read well after a pulse
    mmWrite(2'd1, 32'h0000_0028);
    tick(10);
    pulseTrain(2, 40);
    mmRead(2'd2, d);
    tick(10);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule